// File: doc/BRIEF.md
# Thermal Sensor Auto-Scan Monitor

This block runs unattended temperature supervision for up to four sensor channels. Software programs the thresholds, debounce counts, sampling periods and output routing through a small 32-bit register port. It then sets the automatic-mode bit. From that point a period timer starts a scan of all enabled channels, lowest index first. Each scan issues one conversion request at a time to an external converter and waits for its done strobe. Each returned code is stored and compared against that channel's alarm threshold and shutdown threshold.

A separate run-length counter per channel and per threshold turns a steady over-threshold condition into a sticky pending event. Pending bits drive an interrupt line. Shutdown events also drive a pin-style output, a reset-unit request, or both, chosen per channel. The pin output has a programmable active level. While any enabled channel's latest code is past its alarm threshold, the idle time between scans uses a shorter "hot" period.

Byte offsets, decoded on `reg_addr`: 0x00 settle interval; 0x04 mode; 0x08 enables and routing; 0x0C pending; 0x20+4·ch latest code; 0x30+4·ch alarm threshold; 0x40+4·ch shutdown threshold; 0x60 alarm debounce; 0x64 shutdown debounce; 0x68 normal idle period; 0x6C hot idle period.

Top module: `thermal_monitor`

## Requirements
- R1: After reset, `irq`, `shut_rst_req` and `adc_start` are 0, `shut_pin` is 1 (inactive at the default low active level), and the pending and mode registers read 0.
- R2: Threshold, debounce and period registers read back what was written, truncated to their stored widths (codes 12 bits, debounce counts 4 bits, periods 16 bits), with upper bits reading 0.
- R3: Mode bit 0 enables scanning and mode bit 4+ch enables channel ch. Each scan requests enabled channels in ascending order, one at a time, and skips disabled ones. `adc_start` is a single-cycle pulse. No request starts while bit 0 is 0.
- R4: The code returned with `adc_done` is readable at 0x20+4·ch from the cycle after the done strobe.
- R5: With mode bit 1 at 0, a sample is over a threshold when code ≤ threshold. With bit 1 at 1, it is over when code ≥ threshold. Equality counts as over.
- R6: An alarm (shutdown) event occurs on a sample that completes a run of at least N consecutive over-alarm (over-shutdown) samples of that channel, N being the count at 0x60 (0x64). A sample that is not over restarts the run.
- R7: Pending bit ch (alarm) and bit 4+ch (shutdown) at 0x0C are set by events. Writing 1 clears a bit and writing 0 leaves it. An event in the same cycle as a clear wins.
- R8: `irq` is high exactly when some pending alarm bit ch has enable bit ch at 0x08 set, or some pending shutdown bit ch is routed by bit 4+ch or bit 8+ch at 0x08.
- R9: The shutdown condition is active while pending shutdown bit ch is set with bit 4+ch at 0x08 (pin) or bit 8+ch (reset-unit request, `shut_rst_req` high). It stays active until the pending bit is cleared.
- R10: `shut_pin` is driven high when active if mode bit 8 is 1, and driven low when active if mode bit 8 is 0. Otherwise it sits at the opposite level.
- R11: Between scans the block idles for the normal period (0x68) in clock cycles. It uses the hot period (0x6C) instead while any enabled channel's latest code is over its alarm threshold.
- R12: The value written to 0x00 (low 16 bits) appears on `adc_settle` and reads back at 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| adc_start | output | 1 | Conversion request pulse |
| adc_chan | output | 2 | Channel of the current request |
| adc_done | input | 1 | Conversion finished strobe |
| adc_data | input | 12 | Converted code, valid with `adc_done` |
| adc_settle | output | 16 | Settling interval for the converter |
| irq | output | 1 | Interrupt request |
| shut_pin | output | 1 | Shutdown pin, programmable active level |
| shut_rst_req | output | 1 | Shutdown request to the reset unit, active high |

## Verification
A stuck or wrong run-length counter shows up as a pending bit, and so as an edge on `irq` or a shutdown output, appearing one sample early or late. The bench compares those three outputs against its own model on every clock, so a miscount is reported in the cycle after the offending done strobe. A wrong channel pointer or skipped enable appears at once as an out-of-order or disabled request on `adc_chan`. A timer that loads the wrong period only becomes visible as a scan-to-scan spacing off by the period difference, one full scan later.

// File: rtl/tm_pkg.sv
// Shared register offsets and state encoding for the thermal monitor.
// Assumes a byte-addressed 8-bit offset space with 32-bit registers.
package tm_pkg;
    localparam logic [7:0] A_SETTLE = 8'h00;
    localparam logic [7:0] A_MODE   = 8'h04;
    localparam logic [7:0] A_IEN    = 8'h08;
    localparam logic [7:0] A_PEND   = 8'h0C;
    localparam logic [7:0] A_DATA   = 8'h20;
    localparam logic [7:0] A_ATHR   = 8'h30;
    localparam logic [7:0] A_STHR   = 8'h40;
    localparam logic [7:0] A_ADB    = 8'h60;
    localparam logic [7:0] A_SDB    = 8'h64;
    localparam logic [7:0] A_PER    = 8'h68;
    localparam logic [7:0] A_PERH   = 8'h6C;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SEL,
        SQ_WAIT
    } seq_state_t;
endpackage

// File: rtl/tm_seq.sv
// Scan sequencer: idle timer plus ascending channel walk.
// The timer counts only while idle; when the selected limit is reached a
// scan starts at channel 0. Assumes adc_done only arrives while waiting.
module tm_seq import tm_pkg::*; #(
    parameter int NCH = 4,
    parameter int PW  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   auto_en,
    input  logic [NCH-1:0]         chan_en,
    input  logic                   hot,
    input  logic [PW-1:0]          per,
    input  logic [PW-1:0]          per_hot,
    input  logic                   adc_done,
    output logic                   adc_start,
    output logic [$clog2(NCH)-1:0] adc_chan,
    output logic                   smp_vld
);
    localparam int CW = $clog2(NCH);
    localparam logic [CW-1:0] LAST = CW'(NCH - 1);

    seq_state_t    state;
    logic [PW-1:0] cnt;
    logic [CW-1:0] ch;
    logic [PW:0]   lim;
    logic          at_last;

    // Pick the idle limit and detect the final channel
    always_comb begin
        lim     = {1'b0, (hot ? per_hot : per)};
        at_last = (ch == LAST);
    end

    // Timer and channel-walk state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            cnt   <= '0;
            ch    <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (!auto_en) begin
                        cnt <= '0;
                    end else if (({1'b0, cnt} + (PW+1)'(1)) >= lim) begin
                        cnt   <= '0;
                        ch    <= '0;
                        state <= SQ_SEL;
                    end else begin
                        cnt <= cnt + PW'(1);
                    end
                end
                SQ_SEL: begin
                    if (chan_en[ch])  state <= SQ_WAIT;
                    else if (at_last) state <= SQ_IDLE;
                    else              ch    <= ch + CW'(1);
                end
                SQ_WAIT: begin
                    if (adc_done) begin
                        if (at_last) state <= SQ_IDLE;
                        else begin
                            ch    <= ch + CW'(1);
                            state <= SQ_SEL;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign adc_start = (state == SQ_SEL) && chan_en[ch];
    assign adc_chan  = ch;
    assign smp_vld   = (state == SQ_WAIT) && adc_done;
endmodule

// File: rtl/tm_chan.sv
// Per-channel result store, threshold compare and run-length debounce.
// Events are combinational on the sample strobe; counters saturate.
module tm_chan #(
    parameter int DW  = 12,
    parameter int DBW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_vld,
    input  logic [DW-1:0]  smp_data,
    input  logic [DW-1:0]  alm_thr,
    input  logic [DW-1:0]  sht_thr,
    input  logic [DBW-1:0] alm_db,
    input  logic [DBW-1:0] sht_db,
    input  logic           dir_up,
    output logic [DW-1:0]  data_q,
    output logic           hot_q,
    output logic           alm_evt,
    output logic           sht_evt
);
    localparam logic [DBW-1:0] CMAX = '1;

    logic [DBW-1:0] acnt, scnt, acnt_nx, scnt_nx;
    logic           over_a, over_s;

    // Compare against both thresholds and advance the run counters
    always_comb begin
        over_a  = dir_up ? (smp_data >= alm_thr) : (smp_data <= alm_thr);
        over_s  = dir_up ? (smp_data >= sht_thr) : (smp_data <= sht_thr);
        acnt_nx = !over_a ? '0 : ((acnt == CMAX) ? CMAX : acnt + DBW'(1));
        scnt_nx = !over_s ? '0 : ((scnt == CMAX) ? CMAX : scnt + DBW'(1));
        alm_evt = smp_vld && over_a && (acnt_nx >= alm_db);
        sht_evt = smp_vld && over_s && (scnt_nx >= sht_db);
    end

    // Capture the sample and the run lengths
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            hot_q  <= 1'b0;
            acnt   <= '0;
            scnt   <= '0;
        end else if (smp_vld) begin
            data_q <= smp_data;
            hot_q  <= over_a;
            acnt   <= acnt_nx;
            scnt   <= scnt_nx;
        end
    end
endmodule

// File: rtl/thermal_monitor.sv
// Thermal auto-scan monitor top: register file, pending bits and output
// routing around the sequencer and the per-channel units.
// Assumes 2 <= NCH <= 4 (field positions 4+ch and 8+ch are fixed).
module thermal_monitor import tm_pkg::*; #(
    parameter int NCH = 4,
    parameter int DW  = 12,
    parameter int DBW = 4,
    parameter int PW  = 16,
    parameter int SW  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [7:0]             reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    output logic                   adc_start,
    output logic [$clog2(NCH)-1:0] adc_chan,
    input  logic                   adc_done,
    input  logic [DW-1:0]          adc_data,
    output logic [SW-1:0]          adc_settle,
    output logic                   irq,
    output logic                   shut_pin,
    output logic                   shut_rst_req
);
    logic [SW-1:0]  settle_q;
    logic           auto_q, dir_q, pol_q;
    logic [NCH-1:0] chen_q, ien_a_q, ien_p_q, ien_r_q, pend_a_q, pend_s_q;
    logic [DW-1:0]  athr_q [NCH];
    logic [DW-1:0]  sthr_q [NCH];
    logic [DBW-1:0] adb_q, sdb_q;
    logic [PW-1:0]  per_q, perh_q;
    logic [DW-1:0]  data_w [NCH];
    logic [NCH-1:0] hot_w, aevt_w, sevt_w, clr_a, clr_s;
    logic           smp_vld, wr_pend, unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign wr_pend      = reg_we && (reg_addr == A_PEND);
    assign clr_a        = wr_pend ? reg_wdata[0 +: NCH] : '0;
    assign clr_s        = wr_pend ? reg_wdata[4 +: NCH] : '0;

    // Configuration register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_q <= '0; auto_q <= 1'b0; dir_q <= 1'b0; pol_q <= 1'b0;
            chen_q <= '0; ien_a_q <= '0; ien_p_q <= '0; ien_r_q <= '0;
            adb_q <= '0; sdb_q <= '0; per_q <= '0; perh_q <= '0;
            for (int i = 0; i < NCH; i++) begin
                athr_q[i] <= '0;
                sthr_q[i] <= '0;
            end
        end else if (reg_we) begin
            case (reg_addr)
                A_SETTLE: settle_q <= reg_wdata[SW-1:0];
                A_MODE: begin
                    auto_q <= reg_wdata[0];
                    dir_q  <= reg_wdata[1];
                    chen_q <= reg_wdata[4 +: NCH];
                    pol_q  <= reg_wdata[8];
                end
                A_IEN: begin
                    ien_a_q <= reg_wdata[0 +: NCH];
                    ien_p_q <= reg_wdata[4 +: NCH];
                    ien_r_q <= reg_wdata[8 +: NCH];
                end
                A_ADB:  adb_q  <= reg_wdata[DBW-1:0];
                A_SDB:  sdb_q  <= reg_wdata[DBW-1:0];
                A_PER:  per_q  <= reg_wdata[PW-1:0];
                A_PERH: perh_q <= reg_wdata[PW-1:0];
                default: ;
            endcase
            for (int i = 0; i < NCH; i++) begin
                if (reg_addr == A_ATHR + 8'(4*i)) athr_q[i] <= reg_wdata[DW-1:0];
                if (reg_addr == A_STHR + 8'(4*i)) sthr_q[i] <= reg_wdata[DW-1:0];
            end
        end
    end

    // Sticky pending bits: clear by writing one, events win
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_a_q <= '0;
            pend_s_q <= '0;
        end else begin
            pend_a_q <= (pend_a_q & ~clr_a) | aevt_w;
            pend_s_q <= (pend_s_q & ~clr_s) | sevt_w;
        end
    end

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_SETTLE: reg_rdata[SW-1:0] = settle_q;
            A_MODE: begin
                reg_rdata[0] = auto_q;
                reg_rdata[1] = dir_q;
                reg_rdata[4 +: NCH] = chen_q;
                reg_rdata[8] = pol_q;
            end
            A_IEN: begin
                reg_rdata[0 +: NCH] = ien_a_q;
                reg_rdata[4 +: NCH] = ien_p_q;
                reg_rdata[8 +: NCH] = ien_r_q;
            end
            A_PEND: begin
                reg_rdata[0 +: NCH] = pend_a_q;
                reg_rdata[4 +: NCH] = pend_s_q;
            end
            A_ADB:  reg_rdata[DBW-1:0] = adb_q;
            A_SDB:  reg_rdata[DBW-1:0] = sdb_q;
            A_PER:  reg_rdata[PW-1:0]  = per_q;
            A_PERH: reg_rdata[PW-1:0]  = perh_q;
            default: ;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (reg_addr == A_DATA + 8'(4*i)) reg_rdata[DW-1:0] = data_w[i];
            if (reg_addr == A_ATHR + 8'(4*i)) reg_rdata[DW-1:0] = athr_q[i];
            if (reg_addr == A_STHR + 8'(4*i)) reg_rdata[DW-1:0] = sthr_q[i];
        end
    end

    tm_seq #(.NCH(NCH), .PW(PW)) u_seq (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_q), .chan_en(chen_q),
        .hot(|(hot_w & chen_q)), .per(per_q), .per_hot(perh_q),
        .adc_done(adc_done), .adc_start(adc_start), .adc_chan(adc_chan),
        .smp_vld(smp_vld)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        tm_chan #(.DW(DW), .DBW(DBW)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .smp_vld(smp_vld && (adc_chan == ($clog2(NCH))'(g))),
            .smp_data(adc_data), .alm_thr(athr_q[g]), .sht_thr(sthr_q[g]),
            .alm_db(adb_q), .sht_db(sdb_q), .dir_up(dir_q),
            .data_q(data_w[g]), .hot_q(hot_w[g]),
            .alm_evt(aevt_w[g]), .sht_evt(sevt_w[g])
        );
    end

    assign adc_settle   = settle_q;
    assign irq          = |(pend_a_q & ien_a_q) | |(pend_s_q & (ien_p_q | ien_r_q));
    assign shut_rst_req = |(pend_s_q & ien_r_q);
    assign shut_pin     = pol_q ~^ (|(pend_s_q & ien_p_q));
endmodule

// File: rtl/tm_checker.sv
// Temporal checks on the thermal monitor, attached by bind.
module tm_checker #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           reg_we,
    input logic [7:0]     reg_addr,
    input logic [31:0]    reg_wdata,
    input logic           adc_start,
    input logic           adc_done,
    input logic           irq,
    input logic           shut_rst_req,
    input logic [NCH-1:0] pend_a,
    input logic [NCH-1:0] pend_s
);
    // R3: a request lasts exactly one cycle
    p_single_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    // R7: a write of ones with no sample in flight clears those bits
    p_clear_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 8'h0C && !adc_done) |=>
        (((pend_a & $past(reg_wdata[0 +: NCH])) == '0) &&
         ((pend_s & $past(reg_wdata[4 +: NCH])) == '0)));

    // R6: pending bits only rise on a completed sample
    p_set_on_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (((pend_a & ~$past(pend_a)) != '0) || ((pend_s & ~$past(pend_s)) != '0))
        |-> $past(adc_done));

    // R8: the interrupt needs a pending bit
    p_irq_needs_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((pend_a != '0) || (pend_s != '0)));

    // R9: the reset request only drops after a register write
    p_shut_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shut_rst_req) |-> $past(reg_we));
endmodule

bind thermal_monitor tm_checker #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .adc_start(adc_start), .adc_done(adc_done),
    .irq(irq), .shut_rst_req(shut_rst_req),
    .pend_a(pend_a_q), .pend_s(pend_s_q)
);

// File: tb/tb_thermal_monitor.sv
`timescale 1ns/1ps
module tb_thermal_monitor;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        adc_start;
    logic [1:0]  adc_chan;
    logic        adc_done = 1'b0;
    logic [11:0] adc_data = '0;
    logic [15:0] adc_settle;
    logic        irq, shut_pin, shut_rst_req;

    always #10 clk = ~clk;

    thermal_monitor dut (.*);

    int n_tests = 0, n_fail = 0, cyc = 0;
    // reference model state
    logic [11:0] sensor [4];
    logic [11:0] m_athr [4];
    logic [11:0] m_sthr [4];
    int          m_acnt [4];
    int          m_scnt [4];
    int          samp_cnt [4];
    logic [3:0]  m_pa = '0, m_ps = '0, m_chen = '0;
    logic [11:0] m_ien = '0;
    int          m_adb = 0, m_sdb = 0;
    logic        m_dir = 0, m_pol = 0, m_auto = 0, running = 0;
    // stimulus and responder state
    int          resp_cnt = 0, t0 = 0, last_gap = 0, n_req = 0;
    logic [1:0]  resp_ch = '0, done_ch = '0;
    int          req_q[$];
    logic        wr_req = 0;
    logic [7:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, last_rdata = '0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model update for one returned conversion
    task automatic model_sample(input int ch, input logic [11:0] d);
        bit oa, os;
        oa = m_dir ? (d >= m_athr[ch]) : (d <= m_athr[ch]);
        os = m_dir ? (d >= m_sthr[ch]) : (d <= m_sthr[ch]);
        m_acnt[ch] = oa ? ((m_acnt[ch] < 15) ? m_acnt[ch] + 1 : 15) : 0;
        m_scnt[ch] = os ? ((m_scnt[ch] < 15) ? m_scnt[ch] + 1 : 15) : 0;
        if (oa && m_acnt[ch] >= m_adb) m_pa[ch] = 1'b1;
        if (os && m_scnt[ch] >= m_sdb) m_ps[ch] = 1'b1;
        samp_cnt[ch]++;
    endtask

    // One clock: apply last cycle's effects to the model, compare, drive
    task automatic step();
        bit act_pin, e_irq, e_rst, e_pin;
        @(negedge clk);
        cyc++;
        last_rdata = reg_rdata;
        if (reg_we) begin
            case (reg_addr)
                8'h04: begin m_auto = reg_wdata[0]; m_dir = reg_wdata[1];
                             m_chen = reg_wdata[7:4]; m_pol = reg_wdata[8]; end
                8'h08: m_ien = reg_wdata[11:0];
                8'h0C: begin m_pa &= ~reg_wdata[3:0]; m_ps &= ~reg_wdata[7:4]; end
                8'h60: m_adb = int'(reg_wdata[3:0]);
                8'h64: m_sdb = int'(reg_wdata[3:0]);
                default: for (int i = 0; i < 4; i++) begin
                    if (reg_addr == 8'h30 + 8'(4*i)) m_athr[i] = reg_wdata[11:0];
                    if (reg_addr == 8'h40 + 8'(4*i)) m_sthr[i] = reg_wdata[11:0];
                end
            endcase
        end
        if (adc_done) model_sample(int'(done_ch), adc_data);
        if (running) begin
            e_irq   = |(m_pa & m_ien[3:0]) || |(m_ps & (m_ien[7:4] | m_ien[11:8]));
            e_rst   = |(m_ps & m_ien[11:8]);
            act_pin = |(m_ps & m_ien[7:4]);
            e_pin   = m_pol ? act_pin : !act_pin;
            chk(irq == e_irq, "R8 irq", irq, e_irq);
            chk(shut_rst_req == e_rst, "R9 shut_rst_req", shut_rst_req, e_rst);
            chk(shut_pin == e_pin, "R10 shut_pin", shut_pin, e_pin);
        end
        reg_we = 1'b0;
        adc_done = 1'b0;
        if (resp_cnt > 0) begin
            resp_cnt--;
            if (resp_cnt == 0) begin
                adc_done = 1'b1;
                adc_data = sensor[resp_ch];
                done_ch  = resp_ch;
            end
        end
        if (adc_start) begin
            chk(m_chen[adc_chan] && resp_cnt == 0, "R3 request on enabled idle channel",
                adc_chan, m_chen);
            req_q.push_back(int'(adc_chan));
            n_req++;
            if (adc_chan == 2'd0) begin
                if (t0 > 0) last_gap = cyc - t0;
                t0 = cyc;
            end
            resp_cnt = LAT;
            resp_ch  = adc_chan;
        end
        if (wr_req) begin
            reg_we = 1'b1; reg_addr = wr_addr; reg_wdata = wr_data; wr_req = 0;
        end else begin
            reg_addr = rd_addr;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_req = 1; wr_addr = a; wr_data = d;
        step();
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        rd_addr = a;
        step();
        step();
        v = last_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wait_samples(input int ch, input int n);
        int target;
        target = samp_cnt[ch] + n;
        while (samp_cnt[ch] < target) step();
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog: actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int g_norm, g_hot, snap;
        for (int i = 0; i < 4; i++) begin
            sensor[i] = 12'hA00; m_athr[i] = '0; m_sthr[i] = '0;
            m_acnt[i] = 0; m_scnt[i] = 0; samp_cnt[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(irq == 0, "R1 irq", irq, 0);
        chk(shut_rst_req == 0, "R1 shut_rst_req", shut_rst_req, 0);
        chk(shut_pin == 1, "R1 shut_pin", shut_pin, 1);
        chk(adc_start == 0, "R1 adc_start", adc_start, 0);
        rst_n = 1'b1;
        running = 1;
        rd(8'h0C, v); chk(v == 0, "R1 pending", v, 0);
        rd(8'h04, v); chk(v == 0, "R1 mode", v, 0);

        // R2: readback with width truncation
        wr(8'h34, 32'hFFFF_F600); rd(8'h34, v); chk(v == 32'h600, "R2 alarm thr", v, 32'h600);
        wr(8'h60, 32'h0000_00F2); rd(8'h60, v); chk(v == 32'h2, "R2 alarm debounce", v, 2);
        wr(8'h68, 32'hABCD_0028); rd(8'h68, v); chk(v == 32'h28, "R2 period", v, 32'h28);
        // R12: settle interval
        wr(8'h00, 32'h0000_0340); rd(8'h00, v);
        chk(v == 32'h340, "R12 settle readback", v, 32'h340);
        chk(adc_settle == 16'h340, "R12 adc_settle", adc_settle, 16'h340);

        for (int i = 0; i < 4; i++) begin
            wr(8'h30 + 8'(4*i), 32'h600);
            wr(8'h40 + 8'(4*i), 32'h500);
        end
        wr(8'h64, 3);
        wr(8'h6C, 10);
        wr(8'h08, 32'h00F);
        wr(8'h04, 32'h071);
        idle(300);
        // R3: ascending order, channel 3 skipped
        chk(req_q.size() >= 6, "R3 request count", req_q.size(), 6);
        for (int i = 0; i < 6; i++)
            chk(req_q[i] == i % 3, "R3 scan order", req_q[i], i % 3);
        rd(8'h24, v); chk(v == 32'hA00, "R4 data ch1", v, 32'hA00);
        g_norm = last_gap;

        // R6: alarm on ch1 after two over samples (code 0x5F0 <= 0x600)
        sensor[1] = 12'h5F0;
        wait_samples(1, 1);
        rd(8'h0C, v); chk(v == 0, "R6 one sample not enough", v, 0);
        wait_samples(1, 1);
        rd(8'h0C, v); chk(v == 32'h2, "R6 alarm after two", v, 2);
        chk(irq == 1, "R8 irq from alarm", irq, 1);
        rd(8'h24, v); chk(v == 32'h5F0, "R4 data ch1 update", v, 32'h5F0);
        idle(300);
        g_hot = last_gap;
        chk(g_norm - g_hot == 30, "R11 hot period shortens gap", g_norm - g_hot, 30);

        // R7: writing zero keeps, writing one clears
        wr(8'h0C, 32'h0); rd(8'h0C, v); chk(v == 32'h2, "R7 write zero keeps", v, 2);
        wr(8'h0C, 32'h2); rd(8'h0C, v); chk(v == 0, "R7 write one clears", v, 0);
        wait_samples(1, 1);
        rd(8'h0C, v); chk(v == 32'h2, "R7 re-set by next event", v, 2);

        // R6: a cool sample restarts the run
        sensor[1] = 12'hA00;
        wait_samples(1, 1);
        wr(8'h0C, 32'hFF);
        sensor[1] = 12'h5F0;
        wait_samples(1, 1);
        rd(8'h0C, v); chk(v == 0, "R6 run restarted", v, 0);
        sensor[1] = 12'hA00;
        wait_samples(1, 1);
        wr(8'h0C, 32'hFF);

        // R9: ch2 shutdown to reset unit, ch1 shutdown to pin
        wr(8'h08, 32'h42F);
        sensor[2] = 12'h400;
        wait_samples(2, 2);
        chk(shut_rst_req == 0, "R6 shutdown debounce", shut_rst_req, 0);
        wait_samples(2, 1);
        step();
        chk(shut_rst_req == 1, "R9 reset request", shut_rst_req, 1);
        chk(shut_pin == 1, "R9 pin not routed for ch2", shut_pin, 1);
        sensor[1] = 12'h400;
        wait_samples(1, 3);
        step();
        chk(shut_pin == 0, "R10 active-low pin", shut_pin, 0);
        wr(8'h04, 32'h171);
        step();
        chk(shut_pin == 1, "R10 active-high pin", shut_pin, 1);
        for (int i = 0; i < 4; i++) sensor[i] = 12'hA00;
        idle(300);
        chk(shut_rst_req == 1, "R9 latched request", shut_rst_req, 1);
        chk(shut_pin == 1, "R9 latched pin", shut_pin, 1);
        wr(8'h0C, 32'hF0);
        step();
        chk(shut_rst_req == 0, "R9 cleared request", shut_rst_req, 0);
        chk(shut_pin == 0, "R9 cleared pin inactive high-pol", shut_pin, 0);
        wr(8'h0C, 32'hFF);

        // R5: rising-code direction, channel 0 only, equality counts
        wr(8'h04, 32'h113);
        wr(8'h30, 32'h300);
        sensor[0] = 12'h2FF;
        wait_samples(0, 2);
        rd(8'h0C, v); chk(v == 0, "R5 below threshold not over", v, 0);
        sensor[0] = 12'h300;
        wait_samples(0, 2);
        rd(8'h0C, v); chk(v == 32'h1, "R5 equal counts as over", v, 1);

        // R3: no requests with automatic mode off
        wr(8'h04, 32'h112);
        idle(40);
        snap = n_req;
        idle(300);
        chk(n_req == snap, "R3 no request when off", n_req, snap);

        summary();
        $finish;
    end
endmodule